// File: doc/BRIEF.md
# Masked Register/Memory Move Engine

The engine runs 16-bit move commands that transfer a 64-bit word between a comparand register, two mask registers and a small entry array. A move between the array and the comparand can be limited to selected bits by either mask register. A move into the array can also set the validity flag of the target entry. Every array access goes through an address register. After each move that touches the array, that register advances by one, goes back by one, or stays where it is, depending on a mode held in a control register.

A command either uses the address register as it stands, or asks for an absolute address. In the second case the engine raises `busy` and treats the next command write as the address word. It loads the address register from that word and then runs the move at that address. A separate load port writes the comparand, both masks and the control register directly, so that software can set up operands.

Top module: `mmove_top`

## Requirements
- R1: After reset the address register, comparand, both masks, every array entry and every validity flag are zero, `busy` is low, and the step mode is increment.
- R2: A command word acts only when bits 15:12 are 0000 and bits 10:8 are 011; any other word outside the address phase changes nothing.
- R3: Field layout: bit 11 is the absolute-address flag, bits 7:6 the mask select and bits 5:3 the destination. Location codes are 000 comparand, 001 mask 1, 010 mask 2 and 100 array entry at the address register. When the destination is not 100, bits 2:0 give the source with the same codes. When the destination is 100, bits 1:0 give the source (00 comparand, 01 mask 1, 10 mask 2, 11 array) and bit 2 is the validity flag. Any other destination or source code is reserved.
- R4: A move with no masking in effect copies all 64 source bits to the destination.
- R5: Mask select 01 picks mask 1, 10 picks mask 2, and 00 or 11 means no mask. Masking applies only to moves between the comparand and the array. In such a move only the destination bits whose mask bit is 0 change.
- R6: A move into the array with bit 2 set marks that entry valid. With bit 2 clear, the entry's validity is left as it was. Validity flags are never cleared.
- R7: A command with bit 11 set raises `busy` from the next cycle. The following command write loads the address register from its low address bits, and the move runs at that address.
- R8: After a move whose source or destination is the array, the address register steps from the address just used. Mode 00 increments, 01 decrements, and 10 or 11 holds. Stepping wraps within the array depth.
- R9: A move with identical source and destination, or with a reserved code, changes no data and does not step. With bit 11 set, the address word is still loaded.
- R10: The load port writes the comparand (select 00), mask 1 (01), mask 2 (10) or the step mode from data bits 1:0 (11). The new value shows on the cycle after the write.
- R11: While `busy` is high, the next command write is taken as the address whatever its upper bits hold, and `busy` falls after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command write strobe |
| cmdWord | input | 16 | Command or address word |
| ldValid | input | 1 | Register load strobe |
| ldSel | input | 2 | Register chosen for load |
| ldData | input | 64 | Load value |
| busy | output | 1 | Waiting for the address word |
| addrOut | output | 4 | Address register |
| cmpOut | output | 64 | Comparand register |
| validOut | output | 16 | Per-entry validity flags |

## Verification
The bench targets decrement wrap from entry 0 to the top entry. A design that got this wrong would land on an out-of-range or unwrapped address. It checks masked moves in both directions: a faulty design would overwrite protected bits, or mask register-to-register moves that should copy in full. It checks command words that arrive during the address phase, which a faulty decoder would run as instructions. It also checks moves from a location to itself, which a faulty design would step or mark valid. Absolute-form moves with a cleared validity flag must leave validity alone. An array sweep at the end exposes any write that landed at the pre-load address.

// File: rtl/mmove_pkg.sv
package mmove_pkg;
  localparam int CMD_W = 16;

  typedef enum logic [2:0] {
    LOC_CMP  = 3'd0,
    LOC_MR1  = 3'd1,
    LOC_MR2  = 3'd2,
    LOC_MEM  = 3'd4,
    LOC_NONE = 3'd7
  } loc_e;

  typedef struct packed {
    logic             exec;
    logic             loadAddr;
    logic [CMD_W-1:0] addrWord;
    loc_e             src;
    loc_e             dst;
    logic [1:0]       maskSel;
    logic             markValid;
  } strobe_t;

  typedef struct packed {
    loc_e src;
    loc_e dst;
    logic markValid;
    logic ok;
  } decoded_t;

  function automatic loc_e codeToLoc(input logic [2:0] code);
    case (code)
      3'd0: return LOC_CMP;
      3'd1: return LOC_MR1;
      3'd2: return LOC_MR2;
      3'd4: return LOC_MEM;
      default: return LOC_NONE;
    endcase
  endfunction

  // R3 field decode
  function automatic decoded_t decodeMove(input logic [CMD_W-1:0] w);
    decoded_t d;
    d.dst = codeToLoc(w[5:3]);
    d.markValid = 1'b0;
    if (d.dst == LOC_MEM) begin
      d.markValid = w[2];
      d.src = (w[1:0] == 2'b11) ? LOC_MEM : codeToLoc({1'b0, w[1:0]});
    end else begin
      d.src = codeToLoc(w[2:0]);
    end
    // R9: same location or reserved code -> no move
    d.ok = (d.src != LOC_NONE) && (d.dst != LOC_NONE) && (d.src != d.dst);
    return d;
  endfunction
endpackage

// File: rtl/mmove_ctrl.sv
module mmove_ctrl
  import mmove_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdWord,
  output logic             busy,
  output strobe_t          stb
);
  logic             waitAddr;
  logic [CMD_W-1:0] pendWord;
  logic             isMoveOp;
  decoded_t         decNow;
  decoded_t         decPend;

  // R2 opcode match
  assign isMoveOp = (cmdWord[15:12] == 4'b0000) && (cmdWord[10:8] == 3'b011);
  assign decNow   = decodeMove(cmdWord);
  assign decPend  = decodeMove(pendWord);
  assign busy     = waitAddr;

  always_comb begin
    stb           = '0;
    stb.src       = LOC_NONE;
    stb.dst       = LOC_NONE;
    if (cmdValid) begin
      if (waitAddr) begin
        // R7/R11: any word is the address
        stb.loadAddr  = 1'b1;
        stb.addrWord  = cmdWord;
        stb.exec      = decPend.ok;
        stb.src       = decPend.src;
        stb.dst       = decPend.dst;
        stb.maskSel   = pendWord[7:6];
        stb.markValid = decPend.markValid;
      end else if (isMoveOp && !cmdWord[11]) begin
        stb.exec      = decNow.ok;
        stb.src       = decNow.src;
        stb.dst       = decNow.dst;
        stb.maskSel   = cmdWord[7:6];
        stb.markValid = decNow.markValid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitAddr <= 1'b0;
      pendWord <= '0;
    end else if (cmdValid) begin
      if (waitAddr) begin
        waitAddr <= 1'b0;
      end else if (isMoveOp && cmdWord[11]) begin
        waitAddr <= 1'b1;
        pendWord <= cmdWord;
      end
    end
  end

  p_busy_from_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid && cmdWord[11]));

  p_busy_one_word_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> !busy);

  p_exec_distinct_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.exec |-> (stb.src != stb.dst));
endmodule

// File: rtl/mmove_datapath.sv
module mmove_datapath
  import mmove_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              ldValid,
  input  logic [1:0]        ldSel,
  input  logic [DATA_W-1:0] ldData,
  output logic [AW-1:0]     addrOut,
  output logic [DATA_W-1:0] cmpOut,
  output logic [DEPTH-1:0]  validOut
);
  logic [DATA_W-1:0] cmpReg, mr1Reg, mr2Reg;
  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DEPTH-1:0]  validReg;
  logic [AW-1:0]     arReg;
  logic [1:0]        stepMode;

  logic [AW-1:0]     ea, nextAr;
  logic [DATA_W-1:0] memRd, srcVal, dstOld, maskVal, newVal;
  logic              maskOn, memTouched;

  always_comb begin
    ea     = stb.loadAddr ? stb.addrWord[AW-1:0] : arReg;
    memRd  = memArr[ea];
    case (stb.src)
      LOC_CMP: srcVal = cmpReg;
      LOC_MR1: srcVal = mr1Reg;
      LOC_MR2: srcVal = mr2Reg;
      LOC_MEM: srcVal = memRd;
      default: srcVal = '0;
    endcase
    case (stb.dst)
      LOC_CMP: dstOld = cmpReg;
      LOC_MR1: dstOld = mr1Reg;
      LOC_MR2: dstOld = mr2Reg;
      LOC_MEM: dstOld = memRd;
      default: dstOld = '0;
    endcase
    // R5: masking only between comparand and array
    maskOn = ((stb.src == LOC_CMP) && (stb.dst == LOC_MEM)) ||
             ((stb.src == LOC_MEM) && (stb.dst == LOC_CMP));
    if (!maskOn)                  maskVal = '0;
    else if (stb.maskSel == 2'b01) maskVal = mr1Reg;
    else if (stb.maskSel == 2'b10) maskVal = mr2Reg;
    else                          maskVal = '0;
    newVal     = (dstOld & maskVal) | (srcVal & ~maskVal);
    memTouched = (stb.src == LOC_MEM) || (stb.dst == LOC_MEM);
    // R8 step with wrap
    case (stepMode)
      2'b00:   nextAr = (ea == AW'(DEPTH - 1)) ? '0 : ea + AW'(1);
      2'b01:   nextAr = (ea == '0) ? AW'(DEPTH - 1) : ea - AW'(1);
      default: nextAr = ea;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg   <= '0;
      mr1Reg   <= '0;
      mr2Reg   <= '0;
      validReg <= '0;
      arReg    <= '0;
      stepMode <= 2'b00;
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
    end else begin
      if (stb.loadAddr) arReg <= ea;
      if (stb.exec) begin
        case (stb.dst)
          LOC_CMP: cmpReg <= newVal;
          LOC_MR1: mr1Reg <= newVal;
          LOC_MR2: mr2Reg <= newVal;
          LOC_MEM: begin
            memArr[ea] <= newVal;
            if (stb.markValid) validReg[ea] <= 1'b1;
          end
          default: ;
        endcase
        if (memTouched) arReg <= nextAr;
      end
      // R10 load port
      if (ldValid) begin
        case (ldSel)
          2'b00: cmpReg   <= ldData;
          2'b01: mr1Reg   <= ldData;
          2'b10: mr2Reg   <= ldData;
          default: stepMode <= ldData[1:0];
        endcase
      end
    end
  end

  assign addrOut  = arReg;
  assign cmpOut   = cmpReg;
  assign validOut = validReg;

  p_valid_never_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(validReg) & ~validReg) == '0));

  p_mask_protects_cmp_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.exec && stb.dst == LOC_CMP && stb.src == LOC_MEM && !ldValid)
      |=> (((cmpReg ^ $past(cmpReg)) & $past(maskVal)) == '0));

  p_hold_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.exec && memTouched && stepMode[1]) |=> (arReg == $past(ea)));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.exec && !stb.loadAddr && !ldValid)
      |=> ($stable(arReg) && $stable(cmpReg) && $stable(validReg)));
endmodule

// File: rtl/mmove_top.sv
module mmove_top
  import mmove_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              ldValid,
  input  logic [1:0]        ldSel,
  input  logic [DATA_W-1:0] ldData,
  output logic              busy,
  output logic [AW-1:0]     addrOut,
  output logic [DATA_W-1:0] cmpOut,
  output logic [DEPTH-1:0]  validOut
);
  strobe_t stb;

  mmove_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .busy(busy), .stb(stb)
  );

  mmove_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ldValid(ldValid), .ldSel(ldSel),
    .ldData(ldData), .addrOut(addrOut), .cmpOut(cmpOut), .validOut(validOut)
  );
endmodule

// File: tb/mmove_tb.sv
module mmove_top_tb_top;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 0, rstN = 0, cmdValid = 0, ldValid = 0;
  logic [15:0] cmdWord = '0;
  logic [1:0] ldSel = '0;
  logic [63:0] ldData = '0;
  logic busy;
  logic [AW-1:0] addrOut;
  logic [63:0] cmpOut;
  logic [DEPTH-1:0] validOut;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // model state
  logic [63:0] mCmp, mM1, mM2;
  logic [63:0] mMem [DEPTH];
  logic [DEPTH-1:0] mValid;
  logic [AW-1:0] mAr;
  logic [1:0] mMode;
  bit mBusy;
  logic [15:0] mPend;

  always #4 clk = ~clk;

  mmove_top dut_i (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " cmp"}, cmpOut, mCmp);
    check({tag, " addr"}, 64'(addrOut), 64'(mAr));
    check({tag, " valid"}, 64'(validOut), 64'(mValid));
    check({tag, " busy"}, 64'(busy), 64'(mBusy));
  endtask

  function automatic int locOf(logic [2:0] c);
    case (c) 3'd0: return 0; 3'd1: return 1; 3'd2: return 2; 3'd4: return 4; default: return 7; endcase
  endfunction

  function automatic logic [63:0] rdLoc(int l, logic [AW-1:0] a);
    case (l) 0: return mCmp; 1: return mM1; 2: return mM2; default: return mMem[a]; endcase
  endfunction

  task automatic modelMove(logic [15:0] w, logic [AW-1:0] ea);
    int s, d; logic v; logic [63:0] m, nv;
    mAr = ea;
    d = locOf(w[5:3]); v = 0;
    if (d == 4) begin v = w[2]; s = (w[1:0] == 2'b11) ? 4 : locOf({1'b0, w[1:0]}); end
    else s = locOf(w[2:0]);
    if (s == 7 || d == 7 || s == d) return;
    m = 0;
    if ((s == 0 && d == 4) || (s == 4 && d == 0))
      m = (w[7:6] == 2'b01) ? mM1 : (w[7:6] == 2'b10) ? mM2 : 64'd0;
    nv = (rdLoc(d, ea) & m) | (rdLoc(s, ea) & ~m);
    case (d) 0: mCmp = nv; 1: mM1 = nv; 2: mM2 = nv; default: begin mMem[ea] = nv; if (v) mValid[ea] = 1; end endcase
    if (s == 4 || d == 4)
      case (mMode)
        2'b00: mAr = ea + 1'b1;
        2'b01: mAr = ea - 1'b1;
        default: mAr = ea;
      endcase
  endtask

  task automatic cmd(logic [15:0] w, string tag);
    @(negedge clk); cmdValid = 1; cmdWord = w;
    if (mBusy) begin mBusy = 0; modelMove(mPend, w[AW-1:0]); end
    else if (w[15:12] == 0 && w[10:8] == 3'b011) begin
      if (w[11]) begin mBusy = 1; mPend = w; end
      else modelMove(w, mAr);
    end
    @(negedge clk); cmdValid = 0;
    checkAll(tag);
  endtask

  task automatic ld(logic [1:0] sel, logic [63:0] dat, string tag);
    @(negedge clk); ldValid = 1; ldSel = sel; ldData = dat;
    case (sel) 0: mCmp = dat; 1: mM1 = dat; 2: mM2 = dat; default: mMode = dat[1:0]; endcase
    @(negedge clk); ldValid = 0;
    checkAll(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd7121));
    mCmp = 0; mM1 = 0; mM2 = 0; mValid = 0; mAr = 0; mMode = 0; mBusy = 0; mPend = 0;
    for (int i = 0; i < DEPTH; i++) mMem[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkAll("R1 reset");

    cmd(16'h1324, "R2 wrong opcode");
    cmd(16'h0424, "R2 wrong opcode");
    ld(2'b00, 64'hDEAD_BEEF_0123_4567, "R10 load cmp");
    cmd(16'h0324, "R4 R6 cmp to mem valid");          // AR0 -> 1
    cmd(16'h0320, "R6 no valid flag");                // mem[1], no valid
    ld(2'b01, 64'hFFFF_0000_FFFF_0000, "R10 load mask1");
    ld(2'b00, 64'h1111_2222_3333_4444, "R10 load cmp2");
    cmd(16'h0B64, "R7 absolute masked");               // mm=01, to mem, v=1
    check("R7 busy raised", 64'(busy), 64'd1);
    cmd(16'hFFF0, "R11 junk as address R5");            // address 0
    cmd(16'h0B04, "R7 abs mem to cmp");
    cmd(16'h0000, "R7 address zero");
    cmd(16'h0300, "R9 same reg nop");
    cmd(16'h0327, "R9 mem to mem");
    cmd(16'h0318, "R9 reserved dest");
    cmd(16'h0308, "R4 cmp to mask1 no mask applied");
    ld(2'b11, 64'd1, "R10 mode decrement");
    cmd(16'h0B24, "R8 decrement wrap");
    cmd(16'h0000, "R8 wrap to top");
    ld(2'b11, 64'd2, "R10 mode hold");
    cmd(16'h03A4, "R8 hold R5 mask2");
    ld(2'b11, 64'd0, "R10 mode increment");
    cmd(16'h0B24, "R8 increment wrap");
    cmd(16'h000F, "R8 wrap to zero");

    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 9);
      if (r < 2) ld(2'($urandom_range(0, 3)), {$urandom, $urandom}, "R10 random load");
      else if (r == 2) cmd(16'($urandom), "R2 random word");
      else begin
        w = {4'b0000, 1'($urandom_range(0, 3) == 0), 3'b011, 2'($urandom), 3'($urandom), 3'($urandom)};
        if ($urandom_range(0, 1)) w[5:3] = 3'b100;
        cmd(w, "R3 R4 R5 random move");
      end
    end
    if (mBusy) cmd(16'h0003, "R11 close address phase");

    for (int i = 0; i < DEPTH; i++) begin
      cmd(16'h0B04, "R7 sweep");
      cmd(16'(i), "R4 sweep readback");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule